// File: doc/BRIEF.md
# Operand effective address generator

This block works out where an instruction's operand lives, or where a branch goes, for a small CPU with 8-bit data and a 16-bit address space. At the start of an instruction the fetch logic pulses `start_i` and presents the addressing-mode code, the current index register, the address of the opcode byte and, for branches, the already evaluated branch condition. The block latches these values. It then takes the operand bytes that follow the opcode, one per clock, whenever `byte_valid_i` is high.

Once the last required byte has been taken, the block raises `done_o` for one cycle. In that cycle `ea_o` holds the effective address, or the chosen branch destination. `len_o` holds the total instruction length in bytes, and `next_pc_o` holds the sequential address after the instruction, so the fetch unit can move the program counter on. These outputs keep their values until the next accepted start.

Each mode has its own byte count and its own adder rule. The rules are: an absolute address, the index alone in page zero, index plus an 8-bit offset with a 9-bit result, index plus a 16-bit offset, or a signed displacement from the following instruction.

Top module: `opnd_ea_gen`

## Requirements
- R1: Mode code 0 (absolute) takes two operand bytes, the high byte first. `ea_o` equals {first byte, second byte} and `len_o` is 3.
- R2: Mode code 1 (index only) takes no operand bytes. `ea_o` is the index with a high byte of 0x00, `len_o` is 1, and `done_o` is high in the cycle after the start cycle.
- R3: Mode code 2 (index plus byte) takes one operand byte. `ea_o` is the unsigned sum of index and byte, at most 0x01FE, and `len_o` is 2.
- R4: Mode code 3 (index plus word) takes two operand bytes, the high byte first. `ea_o` equals the 16-bit offset plus the unsigned index, modulo 2^16, and `len_o` is 3.
- R5: Mode code 4 (branch) takes one operand byte and `len_o` is 2. When the latched condition is 1, `ea_o` equals (opcode address + 2) plus the byte read as a two's complement value in -128..+127, modulo 2^16.
- R6: In mode code 4, when the latched condition is 0, `ea_o` equals opcode address + 2, whatever the offset byte is.
- R7: Whenever `done_o` is high, `next_pc_o` equals the opcode address plus `len_o`, modulo 2^16.
- R8: While busy, a byte is taken on each clock with `byte_valid_i` high. Cycles with `byte_valid_i` low may fall between bytes. `done_o` is high in the single cycle after the cycle in which the last byte was taken. A byte offered while idle, including in the start cycle itself, is ignored.
- R9: A start pulse while bytes are still awaited is ignored. A start pulse in the cycle where `done_o` is high is accepted.
- R10: Synchronous reset `rst` returns the block to idle with `done_o` low, and drops any partly gathered instruction.
- R11: A start pulse carrying mode code 5, 6 or 7 is ignored. The block stays idle and produces no `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a new address computation |
| mode_i | input | 3 | Addressing-mode code, latched at start |
| index_i | input | 8 | Index register value, latched at start |
| op_addr_i | input | 16 | Address of the opcode byte, latched at start |
| cond_i | input | 1 | Branch condition, latched at start |
| byte_valid_i | input | 1 | Operand byte present on `byte_i` |
| byte_i | input | 8 | Operand byte |
| done_o | output | 1 | Result-ready strobe |
| ea_o | output | 16 | Effective address or branch destination |
| len_o | output | 2 | Instruction length in bytes (1 to 3) |
| next_pc_o | output | 16 | Opcode address plus length |

## Verification
Two events can land in the same cycle: a finished result being shown on `done_o`, and a fresh start pulse for the next instruction. The driver starts the next instruction in exactly the cycle where the previous result is shown. This includes back-to-back index-only starts, which give `done_o` high on consecutive cycles. The scoreboard checks that each result appears in the predicted cycle with its own fields, and that the next result is the correct one. A related clash is also provoked: a start pulse and a stray byte are driven while an instruction is still gathering bytes. The scoreboard then confirms that the ongoing result is unchanged and that no extra strobe appears.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [2:0] {
        MODE_ABS    = 3'd0,
        MODE_IDX0   = 3'd1,
        MODE_IDX8   = 3'd2,
        MODE_IDX16  = 3'd3,
        MODE_BRANCH = 3'd4
    } ea_mode_e;

    localparam int unsigned OPND_MAX = 2;
    localparam int unsigned CNT_W    = $clog2(OPND_MAX + 1);

endpackage

// File: rtl/ea_mode_dec.sv
module ea_mode_dec
    import ea_pkg::*;
(
    input  logic [2:0]       mode_i,
    output logic             legal_o,
    output logic [CNT_W-1:0] opnd_cnt_o,
    output logic [1:0]       len_o
);

    always_comb begin
        legal_o    = 1'b1;
        opnd_cnt_o = '0;
        unique case (mode_i)
            MODE_ABS:    opnd_cnt_o = CNT_W'(2);
            MODE_IDX0:   opnd_cnt_o = CNT_W'(0);
            MODE_IDX8:   opnd_cnt_o = CNT_W'(1);
            MODE_IDX16:  opnd_cnt_o = CNT_W'(2);
            MODE_BRANCH: opnd_cnt_o = CNT_W'(1);
            default: begin
                legal_o    = 1'b0;
                opnd_cnt_o = '0;
            end
        endcase
        // opcode byte plus operand bytes
        len_o = 2'(opnd_cnt_o) + 2'd1;
    end

endmodule

// File: rtl/ea_byte_gather.sv
module ea_byte_gather #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear_i,
    input  logic                    push_i,
    input  logic [DATA_W-1:0]       byte_i,
    output logic [LANES*DATA_W-1:0] lanes_o
);

    logic [DATA_W-1:0] lane_d [LANES];
    logic [DATA_W-1:0] lane_q [LANES];

    // Lane 0 holds the newest byte; earlier bytes move towards the top lane,
    // so a high-byte-first word ends up already in order.
    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        if (gi == 0) begin : g_head
            always_comb begin
                if (clear_i)     lane_d[gi] = '0;
                else if (push_i) lane_d[gi] = byte_i;
                else             lane_d[gi] = lane_q[gi];
            end
        end else begin : g_tail
            always_comb begin
                if (clear_i)     lane_d[gi] = '0;
                else if (push_i) lane_d[gi] = lane_q[gi-1];
                else             lane_d[gi] = lane_q[gi];
            end
        end
        assign lanes_o[gi*DATA_W +: DATA_W] = lane_q[gi];
    end

    always_ff @(posedge clk) begin
        for (int li = 0; li < LANES; li++) begin
            if (rst) lane_q[li] <= '0;
            else     lane_q[li] <= lane_d[li];
        end
    end

endmodule

// File: rtl/ea_calc.sv
module ea_calc
    import ea_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned ADDR_W = 2 * DATA_W
) (
    input  ea_mode_e          mode_i,
    input  logic [DATA_W-1:0] index_i,
    input  logic [ADDR_W-1:0] op_addr_i,
    input  logic [1:0]        len_i,
    input  logic              cond_i,
    input  logic [DATA_W-1:0] hi_i,
    input  logic [DATA_W-1:0] lo_i,
    output logic [ADDR_W-1:0] ea_o,
    output logic [ADDR_W-1:0] next_pc_o
);

    logic [ADDR_W-1:0] idx_zx;
    logic [ADDR_W-1:0] lo_zx;
    logic [ADDR_W-1:0] lo_sx;
    logic [ADDR_W-1:0] word;

    always_comb begin
        idx_zx    = {{DATA_W{1'b0}}, index_i};
        lo_zx     = {{DATA_W{1'b0}}, lo_i};
        lo_sx     = {{DATA_W{lo_i[DATA_W-1]}}, lo_i};
        word      = {hi_i, lo_i};
        next_pc_o = op_addr_i + ADDR_W'(len_i);

        unique case (mode_i)
            MODE_ABS:    ea_o = word;
            MODE_IDX0:   ea_o = idx_zx;
            MODE_IDX8:   ea_o = idx_zx + lo_zx;
            MODE_IDX16:  ea_o = word + idx_zx;
            MODE_BRANCH: ea_o = cond_i ? (next_pc_o + lo_sx) : next_pc_o;
            default:     ea_o = word;
        endcase
    end

endmodule

// File: rtl/opnd_ea_gen.sv
module opnd_ea_gen
    import ea_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [2:0]        mode_i,
    input  logic [DATA_W-1:0] index_i,
    input  logic [ADDR_W-1:0] op_addr_i,
    input  logic              cond_i,
    input  logic              byte_valid_i,
    input  logic [DATA_W-1:0] byte_i,
    output logic              done_o,
    output logic [ADDR_W-1:0] ea_o,
    output logic [1:0]        len_o,
    output logic [ADDR_W-1:0] next_pc_o
);

    typedef struct packed {
        logic              busy;
        logic              done;
        ea_mode_e          mode;
        logic [DATA_W-1:0] index;
        logic [ADDR_W-1:0] op_addr;
        logic              cond;
        logic [1:0]        len;
        logic [CNT_W-1:0]  need;
    } seq_t;

    seq_t st_d, st_q;

    logic             in_legal;
    logic [CNT_W-1:0] in_cnt;
    logic [1:0]       in_len;
    logic             take_start;
    logic             take_byte;
    logic [OPND_MAX*DATA_W-1:0] lanes;

    ea_mode_dec u_dec (
        .mode_i     (mode_i),
        .legal_o    (in_legal),
        .opnd_cnt_o (in_cnt),
        .len_o      (in_len)
    );

    always_comb begin
        take_start = start_i && !st_q.busy && in_legal;
        take_byte  = byte_valid_i && st_q.busy;

        st_d      = st_q;
        st_d.done = 1'b0;

        if (take_start) begin
            st_d.mode    = ea_mode_e'(mode_i);
            st_d.index   = index_i;
            st_d.op_addr = op_addr_i;
            st_d.cond    = cond_i;
            st_d.len     = in_len;
            st_d.need    = in_cnt;
            if (in_cnt == '0) st_d.done = 1'b1;
            else              st_d.busy = 1'b1;
        end else if (take_byte) begin
            st_d.need = st_q.need - CNT_W'(1);
            if (st_q.need == CNT_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{busy: 1'b0, done: 1'b0, mode: MODE_ABS, index: '0,
                      op_addr: '0, cond: 1'b0, len: 2'd3, need: '0};
        end else begin
            st_q <= st_d;
        end
    end

    ea_byte_gather #(
        .DATA_W (DATA_W),
        .LANES  (OPND_MAX)
    ) u_gather (
        .clk     (clk),
        .rst     (rst),
        .clear_i (take_start),
        .push_i  (take_byte),
        .byte_i  (byte_i),
        .lanes_o (lanes)
    );

    ea_calc #(
        .DATA_W (DATA_W)
    ) u_calc (
        .mode_i    (st_q.mode),
        .index_i   (st_q.index),
        .op_addr_i (st_q.op_addr),
        .len_i     (st_q.len),
        .cond_i    (st_q.cond),
        .hi_i      (lanes[2*DATA_W-1:DATA_W]),
        .lo_i      (lanes[DATA_W-1:0]),
        .ea_o      (ea_o),
        .next_pc_o (next_pc_o)
    );

    assign done_o = st_q.done;
    assign len_o  = st_q.len;

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned ADDR_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [2:0]        mode_in,
    input logic              done_o,
    input logic [ADDR_W-1:0] ea_o,
    input logic [1:0]        len_o,
    input logic [ADDR_W-1:0] next_pc_o,
    input logic              busy,
    input logic [2:0]        mode_q,
    input logic              cond_q
);

    assert_abs_len_R1: assert property (@(posedge clk) disable iff (rst)
        (done_o && mode_q == 3'd0) |-> (len_o == 2'd3));

    assert_page0_R2: assert property (@(posedge clk) disable iff (rst)
        (done_o && mode_q == 3'd1) |-> (ea_o[ADDR_W-1:DATA_W] == '0 && len_o == 2'd1));

    assert_idx8_span_R3: assert property (@(posedge clk) disable iff (rst)
        (done_o && mode_q == 3'd2) |-> (ea_o <= ADDR_W'(2 * ((1 << DATA_W) - 1))));

    assert_not_taken_R6: assert property (@(posedge clk) disable iff (rst)
        (done_o && mode_q == 3'd4 && !cond_q) |-> (ea_o == next_pc_o));

    assert_no_spurious_done_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start_i) |=> !done_o);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy);

    assert_bad_mode_R11: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy && mode_in > 3'd4) |=> (!done_o && !busy));

endmodule

bind opnd_ea_gen ea_gen_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .mode_in   (mode_i),
    .done_o    (done_o),
    .ea_o      (ea_o),
    .len_o     (len_o),
    .next_pc_o (next_pc_o),
    .busy      (st_q.busy),
    .mode_q    (st_q.mode),
    .cond_q    (st_q.cond)
);

// File: tb/opnd_ea_gen_bench.sv
module opnd_ea_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [2:0]  mode_i = '0;
    logic [7:0]  index_i = '0;
    logic [15:0] op_addr_i = '0;
    logic        cond_i = 1'b0;
    logic        byte_valid_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic        done_o;
    logic [15:0] ea_o;
    logic [1:0]  len_o;
    logic [15:0] next_pc_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;

    typedef struct {
        logic [15:0] ea;
        logic [1:0]  len;
        logic [15:0] npc;
        int          cyc;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    opnd_ea_gen u_opnd_ea_gen (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
        .index_i(index_i), .op_addr_i(op_addr_i), .cond_i(cond_i),
        .byte_valid_i(byte_valid_i), .byte_i(byte_i), .done_o(done_o),
        .ea_o(ea_o), .len_o(len_o), .next_pc_o(next_pc_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int opnd_count(input int m);
        case (m)
            0: return 2;
            1: return 0;
            2: return 1;
            3: return 2;
            default: return 1;
        endcase
    endfunction

    // Monitor: compares each done strobe against the scoreboard head.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (sb.size() > 0 && sb[0].cyc < cyc) begin
                check(0, sb[0].tag, "missing done", 0, sb[0].cyc);
                void'(sb.pop_front());
            end
            if (done_o) begin
                if (sb.size() == 0) begin
                    check(0, "R8", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.cyc == cyc, e.tag, "done cycle", cyc, e.cyc);
                    check(ea_o == e.ea, e.tag, "ea", ea_o, e.ea);
                    check(len_o == e.len, e.tag, "len", len_o, e.len);
                    check(next_pc_o == e.npc, "R7", "next_pc", next_pc_o, e.npc);
                end
            end
        end
    end

    // Driver: called at a negedge; returns at the negedge where done shows.
    task automatic run_op(input int m, input logic [7:0] idx, input logic [15:0] addr,
                          input bit cnd, input logic [7:0] b0, input logic [7:0] b1,
                          input int gap, input bit noise, input string tag);
        exp_t e;
        int   n;
        logic [15:0] npc;
        n   = opnd_count(m);
        npc = addr + 16'(n + 1);
        e.len = 2'(n + 1);
        e.npc = npc;
        e.tag = tag;
        case (m)
            0: e.ea = {b0, b1};
            1: e.ea = {8'h00, idx};
            2: e.ea = 16'(idx) + 16'(b0);
            3: e.ea = {b0, b1} + 16'(idx);
            default: e.ea = cnd ? npc + {{8{b0[7]}}, b0} : npc;
        endcase
        e.cyc = cyc + 1;
        if (n == 0) sb.push_back(e);
        start_i = 1'b1; mode_i = 3'(m); index_i = idx; op_addr_i = addr; cond_i = cnd;
        byte_valid_i = noise; byte_i = 8'hA5;
        @(negedge clk);
        start_i = 1'b0; byte_valid_i = 1'b0;
        if (n == 0) return;
        for (int k = 0; k < n; k++) begin
            for (int g = 0; g < gap; g++) begin
                start_i = noise; mode_i = 3'd1; index_i = 8'h77;
                byte_valid_i = 1'b0; byte_i = 8'h5A;
                @(negedge clk);
                start_i = 1'b0;
            end
            byte_valid_i = 1'b1;
            byte_i = (k == 0) ? b0 : b1;
            if (k == n - 1) begin
                e.cyc = cyc + 1;
                sb.push_back(e);
            end
            @(negedge clk);
            byte_valid_i = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        check(done_o == 1'b0, "R10", "done after reset", done_o, 0);

        run_op(0, 8'h00, 16'h0100, 0, 8'h12, 8'h34, 0, 0, "R1");
        run_op(1, 8'hFF, 16'h0200, 0, 8'h00, 8'h00, 0, 0, "R2");
        run_op(1, 8'h3C, 16'h0201, 0, 8'h00, 8'h00, 0, 1, "R2");
        run_op(2, 8'hFF, 16'h0300, 0, 8'hFF, 8'h00, 0, 0, "R3");
        run_op(2, 8'h10, 16'h0302, 0, 8'h05, 8'h00, 1, 1, "R3");
        run_op(3, 8'h20, 16'h0400, 0, 8'hFF, 8'hF0, 0, 0, "R4");
        run_op(3, 8'h01, 16'hFFFE, 0, 8'h12, 8'h00, 0, 0, "R7");
        run_op(4, 8'h00, 16'h0010, 1, 8'h80, 8'h00, 0, 0, "R5");
        run_op(4, 8'h00, 16'hFFF0, 1, 8'h7F, 8'h00, 0, 0, "R5");
        run_op(4, 8'h00, 16'h0500, 0, 8'h80, 8'h00, 0, 0, "R6");
        run_op(0, 8'h00, 16'h0600, 0, 8'hBE, 8'hEF, 3, 1, "R8");
        run_op(1, 8'h42, 16'h0700, 0, 8'h00, 8'h00, 0, 0, "R9");
        idle(1);

        // R11: reserved mode codes
        for (int m = 5; m < 8; m++) begin
            start_i = 1'b1; mode_i = 3'(m); byte_valid_i = 1'b1; byte_i = 8'h11;
            @(negedge clk);
            start_i = 1'b0;
            for (int i = 0; i < 3; i++) begin
                check(done_o == 1'b0, "R11", "done on reserved mode", done_o, 0);
                @(negedge clk);
            end
            byte_valid_i = 1'b0;
        end

        // R10: reset in the middle of an instruction
        start_i = 1'b1; mode_i = 3'd0; op_addr_i = 16'h0800;
        @(negedge clk);
        start_i = 1'b0; byte_valid_i = 1'b1; byte_i = 8'h01;
        @(negedge clk);
        byte_valid_i = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; byte_valid_i = 1'b1; byte_i = 8'h02;
        @(negedge clk);
        byte_valid_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check(done_o == 1'b0, "R10", "done after mid reset", done_o, 0);
            @(negedge clk);
        end

        // mixed stream
        for (int t = 0; t < 60; t++) begin
            int m;
            m = int'($urandom_range(0, 4));
            run_op(m, 8'($urandom), 16'($urandom), 1'($urandom), 8'($urandom),
                   8'($urandom), int'($urandom_range(0, 2)), 1'($urandom),
                   (m == 0) ? "R1" : (m == 1) ? "R2" : (m == 2) ? "R3" :
                   (m == 3) ? "R4" : "R5");
        end
        idle(4);
        check(sb.size() == 0, "R8", "pending results", sb.size(), 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 20000 && !finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule